// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. There are three request sources. The first is an external pin, after a chosen edge on it. The second is a timer overflow strobe. The third is a conversion-complete strobe from an analog-to-digital converter. Each source has a sticky request flag and its own enable bit. A global enable bit gates all three sources.

The core gives a phase pulse, `t2_tick`, once per instruction cycle. The controller only evaluates requests in a cycle where that pulse is high. A request that arrives between two pulses therefore waits for the next pulse. When a source is eligible and the core's call stack is not full, the controller issues a one-cycle call request. The call request carries a vector address and a source ID, and the highest-priority eligible source wins.

The core answers with `call_ack`. The acknowledge clears the serviced flag and the global enable. A return strobe, `reti`, re-opens the global enable.

Software reads and writes all seven control bits through one word. The word layout is given in R11. The call handshake is a request/acknowledge pair and not a stream: after issuing a call, the controller holds back any further call until the acknowledge arrives. That is the only back-pressure the core applies.

Top module: `pri_irq_ctrl`

## Requirements
- R1: When several sources are eligible on the same tick, the external source wins over the timer source, and the timer source wins over the converter source.
- R2: The vector is 8'h04 for the external source, 8'h08 for the timer and 8'h0C for the converter. The matching `call_id` codes are 0, 1 and 2.
- R3: A source can be serviced only when four conditions all hold: the global enable is set, the source's enable is set, the source's flag is set, and `stack_full` is low.
- R4: Requests are evaluated only in a cycle where `t2_tick` is high. `call_req` rises in the following cycle and stays high for exactly one cycle.
- R5: An acknowledge clears the flag of the serviced source and also clears the global enable.
- R6: A flag stays set while its source or the global enable is disabled. A flag clears only through service or through a software write of zero.
- R7: `tmr_ovf` sets the timer flag and `adc_done` sets the converter flag. If a hardware set and a software write hit the same flag in the same cycle, the hardware set wins.
- R8: `ext_pin` passes through a two-flop synchronizer before edge detection, and `ext_trig` selects the edge: 00 off, 01 rising, 10 falling, 11 both. An edge sets the external flag only when the external enable is set and `ext_pin_is_in` is high.
- R9: `reti` sets the global enable. In the same cycle, an acknowledge has priority over `reti`, and `reti` has priority over a software write of that bit.
- R10: After a call request, no new call request is issued until `call_ack` has been received.
- R11: The control word layout is: bit0 global enable; bits 1, 2, 3 enables for external, timer and converter; bits 4, 5, 6 flags for external, timer and converter. `sw_we` writes all seven bits, and `ctl_q` reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t2_tick | input | 1 | Core phase pulse, evaluation strobe |
| stack_full | input | 1 | Core call stack has no free entry |
| tmr_ovf | input | 1 | Timer overflow strobe |
| adc_done | input | 1 | Conversion-complete strobe |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_pin_is_in | input | 1 | Port direction of the pin is input |
| ext_trig | input | 2 | Edge select code |
| sw_we | input | 1 | Control word write strobe |
| sw_wdata | input | 7 | Control word write data |
| reti | input | 1 | Return-from-interrupt strobe |
| call_ack | input | 1 | Core accepted the call |
| ctl_q | output | 7 | Control word readback |
| call_req | output | 1 | One-cycle vectored call request |
| call_vec | output | 8 | Vector address |
| call_id | output | 2 | Serviced source ID |

## Verification
The hardest state to reach from the ports is a call that has been issued but not yet acknowledged while another tick arrives. The bench holds `call_ack` low across a second `t2_tick` and expects silence on `call_req`. It then acknowledges and raises `reti`, and expects the next-priority source to be served.

Same-cycle collisions also need exact stimulus. The bench drives a hardware strobe together with a clearing software write, and drives an acknowledge together with `reti`. In both cases it reads the control word back to confirm which event won.

// File: rtl/pri_irq_pkg.sv
package pri_irq_pkg;
  localparam int NSRC = 3;
  localparam int IDW  = 2;
  localparam int CTLW = 1 + 2 * NSRC;

  typedef enum logic [IDW-1:0] {
    SRC_EXT = 2'd0,
    SRC_TMR = 2'd1,
    SRC_ADC = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] trig_mode,
  input  logic       arm,
  output logic       edge_hit
);
  import pri_irq_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;

  logic rise, fall;
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    unique case (trig_e'(trig_mode))
      TRIG_RISE: edge_hit = arm & rise;
      TRIG_FALL: edge_hit = arm & fall;
      TRIG_BOTH: edge_hit = arm & (rise | fall);
      default:   edge_hit = 1'b0;
    endcase
  end

  // R8: a hit always coincides with a real change of the synchronized pin
  p_hit_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> (cur != prev_q));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NS = pri_irq_pkg::NSRC,
  parameter int IW = pri_irq_pkg::IDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS-1:0]   hw_set,
  input  logic            sw_we,
  input  logic [2*NS:0]   sw_wdata,
  input  logic            svc_clr,
  input  logic [IW-1:0]   svc_id,
  input  logic            reti,
  output logic            gie,
  output logic [NS-1:0]   en,
  output logic [NS-1:0]   flag,
  output logic [2*NS:0]   ctl_q
);
  localparam int EN_LO = 1;
  localparam int FL_LO = 1 + NS;

  // R9: ack clear > reti set > software write
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       gie <= 1'b0;
    else if (svc_clr) gie <= 1'b0;
    else if (reti)    gie <= 1'b1;
    else if (sw_we)   gie <= sw_wdata[0];

  for (genvar i = 0; i < NS; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     en[i] <= 1'b0;
      else if (sw_we) en[i] <= sw_wdata[EN_LO+i];

    // R7: hardware set wins over write and over service clear
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                               flag[i] <= 1'b0;
      else if (hw_set[i])                       flag[i] <= 1'b1;
      else if (sw_we)                           flag[i] <= sw_wdata[FL_LO+i];
      else if (svc_clr && (svc_id == IW'(i)))   flag[i] <= 1'b0;

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !sw_we && !svc_clr) |=> flag[i]);

    p_hw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[i] |=> flag[i]);
  end

  assign ctl_q = {flag, en, gie};

  p_ack_clears_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_clr |=> !gie);

  p_reti_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !svc_clr) |=> gie);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NS       = pri_irq_pkg::NSRC,
  parameter int IW       = pri_irq_pkg::IDW,
  parameter int VW       = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t2_tick,
  input  logic          stack_full,
  input  logic          gie,
  input  logic [NS-1:0] en,
  input  logic [NS-1:0] flag,
  input  logic          call_ack,
  output logic          call_req,
  output logic [VW-1:0] call_vec,
  output logic [IW-1:0] call_id,
  output logic          svc_clr
);
  logic [NS-1:0] elig;
  logic [IW-1:0] pick;
  logic          any_elig;
  logic          fire;
  logic          pending;

  assign elig     = flag & en & {NS{gie}};
  assign any_elig = |elig;

  // lowest index is highest priority: scan down so it is assigned last
  always_comb begin
    pick = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (elig[i]) pick = IW'(i);
  end

  assign fire    = t2_tick & ~pending & ~stack_full & any_elig;
  assign svc_clr = call_ack & pending;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      call_req <= 1'b0;
      call_vec <= '0;
      call_id  <= '0;
      pending  <= 1'b0;
    end else begin
      call_req <= fire;
      if (fire) begin
        call_id  <= pick;
        call_vec <= VW'(VEC_BASE + VEC_STEP * int'(pick));
        pending  <= 1'b1;
      end else if (call_ack) begin
        pending  <= 1'b0;
      end
    end

  logic [NS-1:0] hi_mask;
  assign hi_mask = NS'((1 << call_id) - 1);

  p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  p_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(t2_tick));

  p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> ($past(gie) && !$past(stack_full)));

  p_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (($past(elig) & hi_mask) == '0));

  p_wait_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !call_ack) |=> !call_req);
endmodule

// File: rtl/pri_irq_ctrl.sv
module pri_irq_ctrl #(
  parameter int VW          = 8,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          t2_tick,
  input  logic                          stack_full,
  input  logic                          tmr_ovf,
  input  logic                          adc_done,
  input  logic                          ext_pin,
  input  logic                          ext_pin_is_in,
  input  logic [1:0]                    ext_trig,
  input  logic                          sw_we,
  input  logic [pri_irq_pkg::CTLW-1:0]  sw_wdata,
  input  logic                          reti,
  input  logic                          call_ack,
  output logic [pri_irq_pkg::CTLW-1:0]  ctl_q,
  output logic                          call_req,
  output logic [VW-1:0]                 call_vec,
  output logic [pri_irq_pkg::IDW-1:0]   call_id
);
  import pri_irq_pkg::*;

  logic            gie;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flag;
  logic [NSRC-1:0] hw_set;
  logic            ext_hit;
  logic            ext_arm;
  logic            svc_clr;

  assign ext_arm = en[SRC_EXT] & ext_pin_is_in;

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (ext_pin),
    .trig_mode (ext_trig),
    .arm       (ext_arm),
    .edge_hit  (ext_hit)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[SRC_EXT] = ext_hit;
    hw_set[SRC_TMR] = tmr_ovf;
    hw_set[SRC_ADC] = adc_done;
  end

  irq_flag_bank #(.NS(NSRC), .IW(IDW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set   (hw_set),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .svc_clr  (svc_clr),
    .svc_id   (call_id),
    .reti     (reti),
    .gie      (gie),
    .en       (en),
    .flag     (flag),
    .ctl_q    (ctl_q)
  );

  irq_arbiter #(
    .NS(NSRC), .IW(IDW), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .t2_tick    (t2_tick),
    .stack_full (stack_full),
    .gie        (gie),
    .en         (en),
    .flag       (flag),
    .call_ack   (call_ack),
    .call_req   (call_req),
    .call_vec   (call_vec),
    .call_id    (call_id),
    .svc_clr    (svc_clr)
  );
endmodule

// File: tb/pri_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pri_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t2_tick = 0, stack_full = 0, tmr_ovf = 0, adc_done = 0;
  logic ext_pin = 0, ext_pin_is_in = 0;
  logic [1:0] ext_trig = 2'b00;
  logic sw_we = 0, reti = 0, call_ack = 0;
  logic [6:0] sw_wdata = '0;
  logic [6:0] ctl_q;
  logic call_req;
  logic [7:0] call_vec;
  logic [1:0] call_id;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pri_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .t2_tick(t2_tick), .stack_full(stack_full),
    .tmr_ovf(tmr_ovf), .adc_done(adc_done), .ext_pin(ext_pin),
    .ext_pin_is_in(ext_pin_is_in), .ext_trig(ext_trig), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .reti(reti), .call_ack(call_ack), .ctl_q(ctl_q),
    .call_req(call_req), .call_vec(call_vec), .call_id(call_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [6:0] w);
    @(negedge clk); sw_we = 1; sw_wdata = w;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic tick();
    @(negedge clk); t2_tick = 1;
    @(negedge clk); t2_tick = 0;
  endtask

  task automatic ack();
    call_ack = 1;
    @(negedge clk); call_ack = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // {ctl[6:0], stack_full, exp_call, exp_id[1:0]}
  // ctl: [6:4] flags adc,tmr,ext  [3:1] enables adc,tmr,ext  [0] global
  localparam logic [10:0] VEC [8] = '{
    {7'b111_111_1, 1'b0, 1'b1, 2'd0},
    {7'b110_111_1, 1'b0, 1'b1, 2'd1},
    {7'b100_111_1, 1'b0, 1'b1, 2'd2},
    {7'b111_110_1, 1'b0, 1'b1, 2'd1},
    {7'b111_111_0, 1'b0, 1'b0, 2'd0},
    {7'b111_111_1, 1'b1, 1'b0, 2'd0},
    {7'b000_111_1, 1'b0, 1'b0, 2'd0},
    {7'b001_010_1, 1'b0, 1'b0, 2'd0}
  };

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] exp_ctl;
    wait_cyc(3);
    check("R11 reset ctl", ctl_q, 7'h00);
    check("R4 reset call_req", call_req, 0);
    @(negedge clk); rst_n = 1;
    wait_cyc(2);

    // table walk: R1 R2 R3 R5
    for (int v = 0; v < 8; v++) begin
      write_ctl(VEC[v][10:4]);
      stack_full = VEC[v][3];
      check("R11 readback", ctl_q, VEC[v][10:4]);
      tick();
      check("R3 call", call_req, VEC[v][2]);
      exp_ctl = VEC[v][10:4];
      if (VEC[v][2]) begin
        check("R1 id", call_id, VEC[v][1:0]);
        check("R2 vector", call_vec, 32'(4 + 4 * VEC[v][1:0]));
        ack();
        exp_ctl[4 + VEC[v][1:0]] = 1'b0;
        exp_ctl[0] = 1'b0;
        check("R5 ack clear", ctl_q, exp_ctl);
      end else begin
        check("R6 no change", ctl_q, exp_ctl);
      end
      stack_full = 0;
    end

    // R7 / R6: timer strobe while masked, flag persists
    write_ctl(7'b0);
    @(negedge clk); tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    check("R7 timer set", ctl_q, 7'b010_000_0);
    tick();
    check("R6 masked no call", call_req, 0);
    wait_cyc(5);
    check("R6 persists", ctl_q, 7'b010_000_0);
    write_ctl(7'b010_010_1);
    wait_cyc(3);
    check("R4 no call without tick", call_req, 0);
    tick();
    check("R4 call after tick", call_req, 1);
    check("R2 timer vector", call_vec, 8'h08);
    @(negedge clk);
    check("R4 single cycle", call_req, 0);
    ack();

    // R7 hw set beats sw write
    @(negedge clk); sw_we = 1; sw_wdata = 7'b0; adc_done = 1;
    @(negedge clk); sw_we = 0; adc_done = 0;
    check("R7 hw over write", ctl_q, 7'b100_000_0);

    // R10 / R9
    write_ctl(7'b011_111_1);
    tick();
    check("R1 ext first", call_id, 2'd0);
    wait_cyc(2);
    tick();
    check("R10 held until ack", call_req, 0);
    ack();
    check("R5 ext cleared", ctl_q, 7'b010_111_0);
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
    check("R9 reti sets gie", ctl_q[0], 1);
    tick();
    check("R10 next after ack", call_req, 1);
    check("R1 timer next", call_id, 2'd1);
    @(negedge clk); call_ack = 1; reti = 1;
    @(negedge clk); call_ack = 0; reti = 0;
    check("R9 ack over reti", ctl_q, 7'b000_111_0);

    // R8 edge modes
    write_ctl(7'b000_001_0);
    ext_pin_is_in = 1; ext_trig = 2'b01;
    @(negedge clk); ext_pin = 1; wait_cyc(4);
    check("R8 rise mode rise", ctl_q[4], 1);
    write_ctl(7'b000_001_0);
    @(negedge clk); ext_pin = 0; wait_cyc(4);
    check("R8 rise mode fall", ctl_q[4], 0);
    ext_trig = 2'b10;
    @(negedge clk); ext_pin = 1; wait_cyc(4);
    check("R8 fall mode rise", ctl_q[4], 0);
    @(negedge clk); ext_pin = 0; wait_cyc(4);
    check("R8 fall mode fall", ctl_q[4], 1);
    write_ctl(7'b000_001_0);
    ext_trig = 2'b11;
    @(negedge clk); ext_pin = 1; wait_cyc(4);
    check("R8 both mode", ctl_q[4], 1);
    write_ctl(7'b000_001_0);
    ext_pin_is_in = 0;
    @(negedge clk); ext_pin = 0; wait_cyc(4);
    check("R8 pin output", ctl_q[4], 0);
    ext_pin_is_in = 1; ext_trig = 2'b00;
    @(negedge clk); ext_pin = 1; wait_cyc(4);
    check("R8 mode off", ctl_q[4], 0);
    write_ctl(7'b000_000_0);
    ext_trig = 2'b11;
    @(negedge clk); ext_pin = 0; wait_cyc(4);
    check("R8 enable off", ctl_q[4], 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule